// File: doc/BRIEF.md
# Windowed Watchdog Timer

This peripheral guards a processor against runaway software. A 12-bit counter counts down by one on each pulse of a slow tick enable, and the system tick rate is 256 pulses per second. Software must restart the counter before it passes zero. It does this by writing a keyed command to the control register. The command must also arrive late enough: once the counter has fallen to the window delta or below. A restart that arrives while the count is still above the delta is an error. Letting the counter run out is also an error. Each error sets a sticky flag in the status register. Depending on the configuration, it also raises the interrupt line or a reset request that lasts a fixed number of clocks.

The configuration sits in a mode register. This register takes only the first write after reset and ignores every later write, so running software cannot weaken the watchdog. The mode register holds the reload value, the window delta, the interrupt and reset routing, the choice of processor-only reset, a disable bit, and two halt options. The halt options freeze the count while the core is idle or in debug. Two state machines form the core of the block:
- The watchdog machine has the states `WD_RUN` and `WD_OFF`. It takes the transition DISABLE from `WD_RUN` to `WD_OFF` on an accepted mode write that has the disable bit set. `WD_OFF` then holds until reset, because no command can leave it.
- The reset stretcher has the states `RS_IDLE` and `RS_HOLD`. It takes TRIGGER from `RS_IDLE` to `RS_HOLD` on a fault while resets are enabled. It takes RETRIGGER inside `RS_HOLD` on a further fault, which restarts the hold count. It takes EXPIRE from `RS_HOLD` back to `RS_IDLE` when the hold count runs out.

Top module: `win_watchdog`

## Requirements
- R1: After reset, the mode register reads 0x3FFF2FFF, the counter shows 0xFFF, both status flags are 0, and irq and rst_req are low.
- R2: The mode register (address 1) accepts the first write after reset and then reads back unchanged after any further write.
- R3: While running and not halted, the counter drops by one for each cycle with tick_en high. An accepted mode write loads the counter with bits [11:0] of the written word. The status register (address 2) shows the count in bits [27:16].
- R4: A write to the control register (address 0) is a restart only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other control write leaves the count and the flags untouched.
- R5: A restart while the count is at or below the delta (mode bits [27:16]), or while the delta is at least the reload value (mode bits [11:0]), reloads the counter. Any other restart sets the window-error flag (status bit 1) and leaves the count unchanged.
- R6: A tick while the count is 0 sets the underflow flag (status bit 0) and reloads the counter.
- R7: With mode bit 15 set, the counter is frozen, restarts have no effect, and no fault occurs.
- R8: With mode bit 29 set, the counter holds while core_idle is high. With mode bit 28 set, it holds while core_debug is high.
- R9: irq is high exactly while mode bit 12 is set and a status flag is set.
- R10: When mode bit 13 is set, a fault drives rst_req high for exactly 4 clocks, starting the cycle after the fault. rst_proc_only follows rst_req when mode bit 14 is also set.
- R11: A read of the status register returns the flags and clears them, unless a new fault occurs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Slow tick enable, one pulse per count step |
| core_idle | input | 1 | Core is idle |
| core_debug | input | 1 | Core is halted in debug |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears status on a status read) |
| bus_addr | input | 2 | Register select: 0 control, 1 mode, 2 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register |
| irq | output | 1 | Fault interrupt |
| rst_req | output | 1 | Reset request pulse |
| rst_proc_only | output | 1 | Reset request limited to the processor |

## Verification
The assertions check the following on every cycle:
- The mode register stays frozen once it is locked.
- The count steps down by exactly one on each unhalted tick.
- The count holds while the core is halted.
- The `WD_OFF` state neither counts nor faults.
- A status read empties the flags.
- The reset pulse neither ends early nor runs past four clocks.

Some behaviours only the bench's scenarios can show:
- The window decision itself, covering an early restart, a restart exactly at the delta, a restart with the wrong key, and a restart with the bit missing.
- Underflow with reload.
- The routing of a fault to irq, to rst_req or to rst_proc_only under different mode words.

Each of these needs a sequence of bus writes and ticks whose expected count the bench computes by hand.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

    // mode word layout
    localparam int VAL_LSB       = 0;
    localparam int DELTA_LSB     = 16;
    localparam int BIT_IRQ_EN    = 12;
    localparam int BIT_RST_EN    = 13;
    localparam int BIT_RST_PROC  = 14;
    localparam int BIT_DISABLE   = 15;
    localparam int BIT_HALT_DBG  = 28;
    localparam int BIT_HALT_IDLE = 29;

    localparam logic [DATA_W-1:0] MODE_RST = 32'h3FFF_2FFF;

    // control word
    localparam int          KEY_LSB     = 24;
    localparam logic [7:0]  RESTART_KEY = 8'hA5;
    localparam int          BIT_RESTART = 0;

    typedef enum logic [0:0] {WD_RUN, WD_OFF}  wd_state_t;
    typedef enum logic [0:0] {RS_IDLE, RS_HOLD} rs_state_t;
endpackage

// File: rtl/wwdt_mode_reg.sv
module wwdt_mode_reg #(
    parameter int                 DATA_W  = 32,
    parameter logic [DATA_W-1:0]  RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] mode_q,
    output logic              locked_q,
    output logic              take
);
    assign take = wr_mode && !locked_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RST_VAL;
            locked_q <= 1'b0;
        end else if (take) begin
            mode_q   <= wdata;
            locked_q <= 1'b1;
        end
    end
endmodule

// File: rtl/wwdt_counter.sv
module wwdt_counter
    import wwdt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             halted,
    input  logic             dis_req,
    input  logic             restart_req,
    input  logic             cfg_take,
    input  logic [CNT_W-1:0] cfg_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic [CNT_W-1:0] delta_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             running,
    output logic             fault_uf,
    output logic             fault_win
);
    wd_state_t state_q, state_d;
    logic      early;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_RUN: if (dis_req) state_d = WD_OFF;   // DISABLE
            WD_OFF: state_d = WD_OFF;                 // terminal until reset
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WD_RUN;
        else        state_q <= state_d;
    end

    // outputs of the state machine
    always_comb begin
        running   = (state_q == WD_RUN);
        early     = (cnt_q > delta_val) && (delta_val < reload_val);
        fault_win = running && !cfg_take && restart_req && early;
        fault_uf  = running && !cfg_take && !restart_req && tick_en
                    && !halted && (cnt_q == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '1;
        end else if (cfg_take) begin
            cnt_q <= cfg_val;
        end else if (running) begin
            if (restart_req) begin
                if (!early) cnt_q <= reload_val;
            end else if (tick_en && !halted) begin
                cnt_q <= (cnt_q == '0) ? reload_val : cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/wwdt_rst_stretch.sv
module wwdt_rst_stretch
    import wwdt_pkg::*;
#(
    parameter int HOLD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rst_req
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    rs_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RS_IDLE: if (trig) begin                 // TRIGGER
                state_d = RS_HOLD;
                cnt_d   = LAST;
            end
            RS_HOLD: if (trig) begin                 // RETRIGGER
                cnt_d   = LAST;
            end else if (cnt_q == '0) begin          // EXPIRE
                state_d = RS_IDLE;
            end else begin
                cnt_d   = cnt_q - 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb rst_req = (state_q == RS_HOLD);
endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
    import wwdt_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int HOLD_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              core_idle,
    input  logic              core_debug,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req,
    output logic              rst_proc_only
);
    logic [DATA_W-1:0] mode_q;
    logic              mode_locked, mode_take;
    logic [CNT_W-1:0]  cnt_q;
    logic              wd_running, fault_uf, fault_win;
    logic              restart_req, rd_stat, halted, dis_req;
    logic [1:0]        flags_q;
    logic [DATA_W-1:0] stat_word;

    assign restart_req = bus_wr && (bus_addr == ADDR_CTRL)
                         && (bus_wdata[KEY_LSB +: 8] == RESTART_KEY)
                         && bus_wdata[BIT_RESTART];
    assign rd_stat     = bus_rd && (bus_addr == ADDR_STAT);
    assign halted      = (core_idle  && mode_q[BIT_HALT_IDLE])
                      || (core_debug && mode_q[BIT_HALT_DBG]);
    assign dis_req     = mode_take ? bus_wdata[BIT_DISABLE] : mode_q[BIT_DISABLE];

    wwdt_mode_reg #(.DATA_W(DATA_W), .RST_VAL(MODE_RST)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_mode  (bus_wr && (bus_addr == ADDR_MODE)),
        .wdata    (bus_wdata),
        .mode_q   (mode_q),
        .locked_q (mode_locked),
        .take     (mode_take)
    );

    wwdt_counter #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .halted      (halted),
        .dis_req     (dis_req),
        .restart_req (restart_req),
        .cfg_take    (mode_take),
        .cfg_val     (bus_wdata[VAL_LSB +: CNT_W]),
        .reload_val  (mode_q[VAL_LSB +: CNT_W]),
        .delta_val   (mode_q[DELTA_LSB +: CNT_W]),
        .cnt_q       (cnt_q),
        .running     (wd_running),
        .fault_uf    (fault_uf),
        .fault_win   (fault_win)
    );

    wwdt_rst_stretch #(.HOLD_CYC(HOLD_CYC)) u_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    ((fault_uf || fault_win) && mode_q[BIT_RST_EN]),
        .rst_req (rst_req)
    );

    // sticky fault flags, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_stat ? 2'b00 : flags_q) | {fault_win, fault_uf};
    end

    always_comb begin
        stat_word                       = '0;
        stat_word[DELTA_LSB +: CNT_W]   = cnt_q;
        stat_word[1:0]                  = flags_q;
        unique case (bus_addr)
            ADDR_MODE: bus_rdata = mode_q;
            ADDR_STAT: bus_rdata = stat_word;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq           = mode_q[BIT_IRQ_EN] && (flags_q != 2'b00);
    assign rst_proc_only = rst_req && mode_q[BIT_RST_PROC];
endmodule

// File: rtl/wwdt_checker.sv
module wwdt_checker
    import wwdt_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int HOLD_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_locked,
    input logic              mode_take,
    input logic [DATA_W-1:0] mode_q,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              running,
    input logic              tick_en,
    input logic              core_idle,
    input logic              core_debug,
    input logic              restart_req,
    input logic              rd_stat,
    input logic              fault_uf,
    input logic              fault_win,
    input logic [1:0]        flags_q,
    input logic              rst_req
);
    localparam int RW = $clog2(HOLD_CYC + 1) + 1;

    logic          halt_now, fault_any;
    logic [RW-1:0] run_len;

    assign halt_now  = (core_idle && mode_q[BIT_HALT_IDLE]) || (core_debug && mode_q[BIT_HALT_DBG]);
    assign fault_any = fault_uf || fault_win;

    always_ff @(posedge clk) begin
        if (!rst_n)                                 run_len <= '0;
        else if (fault_any && mode_q[BIT_RST_EN])   run_len <= '0;
        else if (rst_req)                           run_len <= run_len + 1'b1;
        else                                        run_len <= '0;
    end

    assert_mode_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_locked |=> $stable(mode_q));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_en && !halt_now && !restart_req && !mode_take && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_off_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !mode_take) |=> $stable(cnt_q));

    assert_off_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !fault_any);

    assert_halt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && halt_now && !restart_req && !mode_take) |=> $stable(cnt_q));

    assert_rst_short_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (run_len < RW'(HOLD_CYC)));

    assert_rst_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && run_len < RW'(HOLD_CYC - 1)) |=> rst_req);

    assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !fault_any) |=> (flags_q == 2'b00));
endmodule

bind win_watchdog wwdt_checker #(.CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_locked (mode_locked),
    .mode_take   (mode_take),
    .mode_q      (mode_q),
    .cnt_q       (cnt_q),
    .running     (wd_running),
    .tick_en     (tick_en),
    .core_idle   (core_idle),
    .core_debug  (core_debug),
    .restart_req (restart_req),
    .rd_stat     (rd_stat),
    .fault_uf    (fault_uf),
    .fault_win   (fault_win),
    .flags_q     (flags_q),
    .rst_req     (rst_req)
);

// File: tb/test_win_watchdog.sv
module test_win_watchdog;
    localparam int CLK_PERIOD = 10;

    localparam logic [1:0] OP_TICK = 2'd0, OP_RST = 2'd1, OP_BADKEY = 2'd2, OP_NOBIT = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  reps;
        logic [11:0] cnt;
        logic [1:0]  flg;
    } vec_t;

    // mode: value 0x010, delta 0x008, irq and reset enabled
    localparam vec_t VECS [10] = '{
        '{OP_TICK,   5'd3,  12'd13, 2'b00},   // R3 count down
        '{OP_RST,    5'd1,  12'd13, 2'b10},   // R5 early restart
        '{OP_TICK,   5'd5,  12'd8,  2'b00},   // R3
        '{OP_BADKEY, 5'd1,  12'd8,  2'b00},   // R4 wrong key
        '{OP_RST,    5'd1,  12'd16, 2'b00},   // R5 restart at delta
        '{OP_TICK,   5'd16, 12'd0,  2'b00},   // R3 down to zero
        '{OP_TICK,   5'd1,  12'd16, 2'b01},   // R6 underflow reload
        '{OP_TICK,   5'd10, 12'd6,  2'b00},   // R3
        '{OP_NOBIT,  5'd1,  12'd6,  2'b00},   // R4 restart bit clear
        '{OP_RST,    5'd1,  12'd16, 2'b00}    // R5 restart in window
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, core_idle = 1'b0, core_debug = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req, rst_proc_only;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    win_watchdog i_win_watchdog (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .core_idle(core_idle),
        .core_debug(core_debug), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req), .rst_proc_only(rst_proc_only)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick_en = 0; core_idle = 0; core_debug = 0; bus_wr = 0; bus_rd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    // read with side effects; returns rdata sampled before the edge
    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi;

        // ---- R1 reset state, R8 halt options under default mode ----
        do_reset();
        rd(2'd1, d); chk("R1 mode", d, 32'h3FFF_2FFF);
        rd(2'd2, d); chk("R1 status", d, 32'h0FFF_0000);
        chk("R1 irq/rst", {30'd0, irq, rst_req}, 32'd0);
        core_idle = 1'b1; ticks(2);
        rd(2'd2, d); chk("R8 idle halt", d[27:16], 32'hFFF);
        core_idle = 1'b0; core_debug = 1'b1; ticks(2);
        rd(2'd2, d); chk("R8 debug halt", d[27:16], 32'hFFF);
        core_debug = 1'b0; ticks(2);
        rd(2'd2, d); chk("R8 released", d[27:16], 32'hFFD);

        // ---- R2 write-once mode ----
        do_reset();
        wr(2'd1, 32'h0008_3010);
        wr(2'd1, 32'h0000_0005);
        rd(2'd1, d); chk("R2 mode locked", d, 32'h0008_3010);
        rd(2'd2, d); chk("R3 load on mode write", d[27:16], 32'h010);

        // ---- vector table ----
        foreach (VECS[v]) begin
            unique case (VECS[v].op)
                OP_TICK:   ticks(int'(VECS[v].reps));
                OP_RST:    wr(2'd0, 32'hA500_0001);
                OP_BADKEY: wr(2'd0, 32'h5A00_0001);
                OP_NOBIT:  wr(2'd0, 32'hA500_0002);
            endcase
            rd(2'd2, d);
            chk($sformatf("R3/R4/R5/R6/R11 vec%0d count", v), d[27:16], 32'(VECS[v].cnt));
            chk($sformatf("R4/R5/R6 vec%0d flags", v), d[1:0], 32'(VECS[v].flg));
        end

        // ---- R9, R10, R11: early restart at count 16 ----
        wr(2'd0, 32'hA500_0001);
        chk("R9 irq raised", 32'(irq), 32'd1);
        hi = 0;
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            if (rst_req) hi++;
        end
        chk("R10 pulse length", hi, 32'd4);
        chk("R10 full reset", 32'(rst_proc_only), 32'd0);
        rd(2'd2, d); chk("R5 window flag", d[1:0], 32'b10);
        chk("R11 irq cleared", 32'(irq), 32'd0);
        rd(2'd2, d); chk("R11 flags cleared", d[1:0], 32'd0);

        // ---- R10 processor-only reset, R9 irq disabled ----
        do_reset();
        wr(2'd1, 32'h0002_6002);
        ticks(3);
        chk("R10 rst_req", 32'(rst_req), 32'd1);
        chk("R10 proc only", 32'(rst_proc_only), 32'd1);
        chk("R9 irq masked", 32'(irq), 32'd0);
        rd(2'd2, d); chk("R6 underflow", d, 32'h0002_0001);

        // ---- R7 disable ----
        do_reset();
        wr(2'd1, 32'h0000_A005);
        ticks(10);
        wr(2'd0, 32'hA500_0001);
        rd(2'd2, d); chk("R7 frozen", d, 32'h0005_0000);
        chk("R7 no reset", 32'(rst_req), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule